// File: doc/BRIEF.md
# Display Supply Power-Up Sequencer

This block is the control state machine for a multi-output display power supply. It walks the supply from shutdown to full operation in a fixed order. First the reference comes up. Then the oscillator and the fault detector start, then the input pass-switch gate drive, then auxiliary regulator 1 together with the fault counter. When the converter-enable input rises, the boost converter starts. A digital ramp counter then releases three delayed rails.

The ramp counter stands in for a timing capacitor. It sits at zero until the boost runs, then climbs by one every clock and saturates at its maximum. Each delayed rail has its own threshold, and the three thresholds may be set in any order. Rail P additionally waits for the boost soft-start-done flag. Rail 2 and the open-drain switch drive turn on together. A fault seen while the fault counter is enabled is latched. The latch holds the boost and all delayed rails off until shutdown is pulled low or the input undervoltage flag rises. All inputs are plain level signals; there is no streaming interface.

Top module: `pwrseq_top`

## Requirements
- R1: While `shdn_n` is low, every enable output is low in the same cycle, independent of the sequencer state.
- R2: `ref_en` goes high one clock after an edge that samples `shdn_n` high and `uvlo` low in shutdown. An edge that samples `uvlo` high returns the sequencer to shutdown, so all enables are low from the next cycle.
- R3: `osc_en` and `fdet_en` rise one clock after an edge that samples `ref_ready` high with the reference on. `gate_en` rises exactly one clock after `osc_en`.
- R4: `aux1_en` and `fcnt_en` rise one clock after an edge that samples `gate_ready` high with the gate drive on.
- R5: With the fault counter on and no latched fault, `boost_en` rises one clock after an edge that samples `conv_en` high. An edge that samples `conv_en` low turns the boost and all delayed rails off from the next cycle, and restarts the ramp.
- R6: The ramp is zero in the first boost cycle and grows by one per clock after that. Outside boost it is held at zero.
- R7: `rail_p_en` is high exactly when boosting, the ramp is strictly greater than `thr_p`, and `ss_done` is high. It therefore first rises `thr_p`+1 cycles after `boost_en` if `ss_done` is already high.
- R8: `rail_n_en` is high exactly when boosting and the ramp is strictly greater than `thr_n`, first rising `thr_n`+1 cycles after `boost_en`.
- R9: `rail_2_en` and `sw_drv_en` rise together, `thr_2`+1 cycles after `boost_en`. Any ordering of the three thresholds is valid.
- R10: `fault_in` high at an edge while `fcnt_en` is on sets the fault latch. The next cycle `boost_en` and all delayed rails are low and stay low while the latch holds. `fault_in` has no effect while the fault counter is off.
- R11: The fault latch is cleared only by an edge that samples `shdn_n` low or `uvlo` high. Toggling `conv_en` does not clear it.
- R12: The ramp saturates at 2^RAMP_W-1. A threshold equal to that value never enables its rail, because the comparison is strictly greater-than.
- R13: Each threshold is captured on every clock outside boost. A change to a threshold input during boost has no effect until the boost stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Shutdown, active low |
| uvlo | input | 1 | Input undervoltage flag, high when below the rising threshold |
| ref_ready | input | 1 | Reference has reached regulation |
| gate_ready | input | 1 | Pass-switch gate is fully driven |
| conv_en | input | 1 | Converter enable, starts boost and ramp |
| ss_done | input | 1 | Boost soft-start finished |
| fault_in | input | 1 | Fault detected |
| thr_p | input | RAMP_W | Ramp threshold for rail P |
| thr_n | input | RAMP_W | Ramp threshold for rail N |
| thr_2 | input | RAMP_W | Ramp threshold for rail 2 and switch drive |
| ref_en | output | 1 | Reference enable |
| osc_en | output | 1 | Oscillator enable |
| fdet_en | output | 1 | Fault detector enable |
| gate_en | output | 1 | Pass-switch gate drive enable |
| aux1_en | output | 1 | Auxiliary regulator 1 enable |
| fcnt_en | output | 1 | Fault counter enable |
| boost_en | output | 1 | Boost converter enable |
| rail_p_en | output | 1 | Delayed positive rail enable |
| rail_n_en | output | 1 | Delayed negative rail enable |
| rail_2_en | output | 1 | Delayed rail 2 enable |
| sw_drv_en | output | 1 | Open-drain switch drive enable |

## Verification
Several properties are checked on every cycle:
- nothing is on while shutdown is low;
- each stage only follows the one before it;
- no delayed rail is on without the boost, and rail P also needs soft-start done;
- a latched fault keeps the boost off and only falls when shutdown or undervoltage is sampled;
- the ramp climbs by one per cycle and sticks at its maximum.

The exact number of cycles from boost start to each rail, and the handling of thresholds in various orders, are shown only by the directed scenarios. So are the threshold freeze during boost and the latch surviving a converter-enable toggle.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_REF   = 3'd1,
    ST_OSC   = 3'd2,
    ST_GATE  = 3'd3,
    ST_RDY   = 3'd4,
    ST_BOOST = 3'd5
  } seq_state_e;

  localparam int NUM_RAILS = 3;
  localparam int RAIL_P    = 0;
  localparam int RAIL_N    = 1;
  localparam int RAIL_2    = 2;

endpackage

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic shdn_n,
  input  logic uvlo,
  input  logic ref_ready,
  input  logic gate_ready,
  input  logic conv_en,
  input  logic fault_q,
  output logic ref_on,
  output logic osc_on,
  output logic gate_on,
  output logic aux_on,
  output logic in_boost
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!shdn_n || uvlo) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:   state_d = ST_REF;
        ST_REF:   if (ref_ready) state_d = ST_OSC;
        ST_OSC:   state_d = ST_GATE;
        ST_GATE:  if (gate_ready) state_d = ST_RDY;
        ST_RDY:   if (conv_en && !fault_q) state_d = ST_BOOST;
        ST_BOOST: if (!conv_en || fault_q) state_d = ST_RDY;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  always_comb begin
    ref_on   = 1'b0;
    osc_on   = 1'b0;
    gate_on  = 1'b0;
    aux_on   = 1'b0;
    in_boost = 1'b0;
    unique case (state_q)
      ST_OFF:   ;
      ST_REF:   ref_on = 1'b1;
      ST_OSC:   begin ref_on = 1'b1; osc_on = 1'b1; end
      ST_GATE:  begin ref_on = 1'b1; osc_on = 1'b1; gate_on = 1'b1; end
      ST_RDY:   begin ref_on = 1'b1; osc_on = 1'b1; gate_on = 1'b1; aux_on = 1'b1; end
      ST_BOOST: begin
        ref_on = 1'b1; osc_on = 1'b1; gate_on = 1'b1; aux_on = 1'b1; in_boost = 1'b1;
      end
      default:  ;
    endcase
  end

endmodule

// File: rtl/pwrseq_ramp.sv
module pwrseq_ramp #(
  parameter int RAMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic [RAMP_W-1:0] ramp
);

  localparam logic [RAMP_W-1:0] RAMP_MAX = {RAMP_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ramp <= '0;
    else if (!run)            ramp <= '0;
    else if (ramp != RAMP_MAX) ramp <= ramp + 1'b1;
  end

endmodule

// File: rtl/pwrseq_rail.sv
module pwrseq_rail #(
  parameter int RAMP_W  = 8,
  parameter bit NEED_SS = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [RAMP_W-1:0] thr_in,
  input  logic [RAMP_W-1:0] ramp,
  input  logic              ss_done,
  input  logic              active,
  output logic              hit
);

  logic [RAMP_W-1:0] thr_q;
  logic              ss_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       thr_q <= {RAMP_W{1'b1}};
    else if (capture) thr_q <= thr_in;
  end

  assign ss_ok = NEED_SS ? ss_done : 1'b1;
  assign hit   = active && (ramp > thr_q) && ss_ok;

endmodule

// File: rtl/pwrseq_fault.sv
module pwrseq_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic fault_in,
  input  logic clr,
  output logic latched
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                latched <= 1'b0;
    else if (clr)              latched <= 1'b0;
    else if (arm && fault_in)  latched <= 1'b1;
  end

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int RAMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shdn_n,
  input  logic              uvlo,
  input  logic              ref_ready,
  input  logic              gate_ready,
  input  logic              conv_en,
  input  logic              ss_done,
  input  logic              fault_in,
  input  logic [RAMP_W-1:0] thr_p,
  input  logic [RAMP_W-1:0] thr_n,
  input  logic [RAMP_W-1:0] thr_2,
  output logic              ref_en,
  output logic              osc_en,
  output logic              fdet_en,
  output logic              gate_en,
  output logic              aux1_en,
  output logic              fcnt_en,
  output logic              boost_en,
  output logic              rail_p_en,
  output logic              rail_n_en,
  output logic              rail_2_en,
  output logic              sw_drv_en
);

  logic ref_on, osc_on, gate_on, aux_on, in_boost;
  logic fault_q, fault_clr, rails_active;
  logic [RAMP_W-1:0] ramp_q;
  logic [NUM_RAILS-1:0][RAMP_W-1:0] thr_all;
  logic [NUM_RAILS-1:0] rail_hit;

  pwrseq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .shdn_n     (shdn_n),
    .uvlo       (uvlo),
    .ref_ready  (ref_ready),
    .gate_ready (gate_ready),
    .conv_en    (conv_en),
    .fault_q    (fault_q),
    .ref_on     (ref_on),
    .osc_on     (osc_on),
    .gate_on    (gate_on),
    .aux_on     (aux_on),
    .in_boost   (in_boost)
  );

  assign fault_clr = !shdn_n || uvlo;

  pwrseq_fault u_fault (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      (aux_on),
    .fault_in (fault_in),
    .clr      (fault_clr),
    .latched  (fault_q)
  );

  pwrseq_ramp #(.RAMP_W(RAMP_W)) u_ramp (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (in_boost),
    .ramp  (ramp_q)
  );

  assign thr_all[RAIL_P] = thr_p;
  assign thr_all[RAIL_N] = thr_n;
  assign thr_all[RAIL_2] = thr_2;
  assign rails_active    = in_boost && !fault_q;

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    pwrseq_rail #(
      .RAMP_W  (RAMP_W),
      .NEED_SS (g == RAIL_P)
    ) u_rail (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (!in_boost),
      .thr_in  (thr_all[g]),
      .ramp    (ramp_q),
      .ss_done (ss_done),
      .active  (rails_active),
      .hit     (rail_hit[g])
    );
  end

  assign ref_en    = shdn_n && ref_on;
  assign osc_en    = shdn_n && osc_on;
  assign fdet_en   = shdn_n && osc_on;
  assign gate_en   = shdn_n && gate_on;
  assign aux1_en   = shdn_n && aux_on;
  assign fcnt_en   = shdn_n && aux_on;
  assign boost_en  = shdn_n && rails_active;
  assign rail_p_en = shdn_n && rail_hit[RAIL_P];
  assign rail_n_en = shdn_n && rail_hit[RAIL_N];
  assign rail_2_en = shdn_n && rail_hit[RAIL_2];
  assign sw_drv_en = shdn_n && rail_hit[RAIL_2];

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk #(
  parameter int RAMP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shdn_n,
  input logic              uvlo,
  input logic              conv_en,
  input logic              ss_done,
  input logic              ref_en,
  input logic              osc_en,
  input logic              fdet_en,
  input logic              gate_en,
  input logic              aux1_en,
  input logic              fcnt_en,
  input logic              boost_en,
  input logic              rail_p_en,
  input logic              rail_n_en,
  input logic              rail_2_en,
  input logic              sw_drv_en,
  input logic [RAMP_W-1:0] ramp,
  input logic              in_boost,
  input logic              fault_q
);

  localparam logic [RAMP_W-1:0] RAMP_MAX = {RAMP_W{1'b1}};

  logic any_on;
  assign any_on = ref_en | osc_en | fdet_en | gate_en | aux1_en | fcnt_en |
                  boost_en | rail_p_en | rail_n_en | rail_2_en | sw_drv_en;

  assert_shdn_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |-> !any_on);

  assert_ref_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_en) |-> ($past(shdn_n) && !$past(uvlo)));

  assert_uvlo_shut_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |=> !ref_en);

  assert_osc_needs_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en |-> ref_en);

  assert_gate_after_osc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> $past(osc_en));

  assert_aux_needs_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    aux1_en |-> gate_en);

  assert_conv_low_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |=> !boost_en);

  assert_ramp_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_boost && $past(in_boost) && $past(ramp) != RAMP_MAX) |->
      (ramp == $past(ramp) + 1'b1));

  assert_rail_p_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rail_p_en |-> (ss_done && boost_en));

  assert_rail_n_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rail_n_en |-> boost_en);

  assert_rail2_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rail_2_en |-> (sw_drv_en && boost_en));

  assert_fault_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> !(boost_en || rail_p_en || rail_n_en || rail_2_en || sw_drv_en));

  assert_fault_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_q) |-> (!$past(shdn_n) || $past(uvlo)));

  assert_ramp_sat_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_boost && ramp == RAMP_MAX) |=> (!in_boost || ramp == RAMP_MAX));

endmodule

bind pwrseq_top pwrseq_chk #(.RAMP_W(RAMP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .shdn_n    (shdn_n),
  .uvlo      (uvlo),
  .conv_en   (conv_en),
  .ss_done   (ss_done),
  .ref_en    (ref_en),
  .osc_en    (osc_en),
  .fdet_en   (fdet_en),
  .gate_en   (gate_en),
  .aux1_en   (aux1_en),
  .fcnt_en   (fcnt_en),
  .boost_en  (boost_en),
  .rail_p_en (rail_p_en),
  .rail_n_en (rail_n_en),
  .rail_2_en (rail_2_en),
  .sw_drv_en (sw_drv_en),
  .ramp      (ramp_q),
  .in_boost  (in_boost),
  .fault_q   (fault_q)
);

// File: tb/sim_pwrseq_top.sv
`timescale 1ns/1ps
module sim_pwrseq_top;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n, shdn_n, uvlo, ref_ready, gate_ready, conv_en, ss_done, fault_in;
  logic [W-1:0] thr_p, thr_n, thr_2;
  logic ref_en, osc_en, fdet_en, gate_en, aux1_en, fcnt_en, boost_en;
  logic rail_p_en, rail_n_en, rail_2_en, sw_drv_en;
  logic [10:0] outs;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign outs = {ref_en, osc_en, fdet_en, gate_en, aux1_en, fcnt_en, boost_en,
                 rail_p_en, rail_n_en, rail_2_en, sw_drv_en};

  pwrseq_top #(.RAMP_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .uvlo(uvlo),
    .ref_ready(ref_ready), .gate_ready(gate_ready), .conv_en(conv_en),
    .ss_done(ss_done), .fault_in(fault_in),
    .thr_p(thr_p), .thr_n(thr_n), .thr_2(thr_2),
    .ref_en(ref_en), .osc_en(osc_en), .fdet_en(fdet_en), .gate_en(gate_en),
    .aux1_en(aux1_en), .fcnt_en(fcnt_en), .boost_en(boost_en),
    .rail_p_en(rail_p_en), .rail_n_en(rail_n_en), .rail_2_en(rail_2_en),
    .sw_drv_en(sw_drv_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Walk from shutdown to ready; checks each stage on the way.
  task automatic bring_up();
    @(negedge clk);
    ref_ready = 0; gate_ready = 0; conv_en = 0; uvlo = 0; shdn_n = 1;
    @(negedge clk);
    chk(ref_en && !osc_en, "R2 ref on after leaving shutdown", {ref_en, osc_en}, 2);
    ref_ready = 1;
    @(negedge clk);
    chk(osc_en && fdet_en && !gate_en, "R3 osc/fdet after ref_ready",
        {osc_en, fdet_en, gate_en}, 6);
    @(negedge clk);
    chk(gate_en && !aux1_en, "R3 gate one cycle after osc", {gate_en, aux1_en}, 2);
    gate_ready = 1;
    @(negedge clk);
    chk(aux1_en && fcnt_en && !boost_en, "R4 aux1/fcnt after gate_ready",
        {aux1_en, fcnt_en, boost_en}, 6);
  endtask

  task automatic start_boost();
    conv_en = 1;
    @(negedge clk);
    chk(boost_en, "R5 boost on after conv_en", boost_en, 1);
  endtask

  task automatic run_ramp(input int n, output int tp, output int tn,
                          output int t2, output int ts);
    tp = -1; tn = -1; t2 = -1; ts = -1;
    for (int c = 0; c < n; c++) begin
      if (rail_p_en && tp < 0) tp = c;
      if (rail_n_en && tn < 0) tn = c;
      if (rail_2_en && t2 < 0) t2 = c;
      if (sw_drv_en && ts < 0) ts = c;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 0; shdn_n = 0; uvlo = 0; ref_ready = 0; gate_ready = 0;
    conv_en = 0; ss_done = 0; fault_in = 0;
    thr_p = 0; thr_n = 0; thr_2 = 0;
    repeat (3) @(negedge clk);
    chk(outs == 0, "R1 all off in reset/shutdown", outs, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(outs == 0, "R1 all off while shdn_n low", outs, 0);
  endtask

  task automatic t_uvlo_hold();
    @(negedge clk);
    uvlo = 1; shdn_n = 1;
    repeat (5) @(negedge clk);
    chk(!ref_en, "R2 uvlo holds shutdown", ref_en, 0);
    bring_up();
  endtask

  task automatic t_order_a();
    int tp, tn, t2, ts;
    thr_p = 20; thr_n = 5; thr_2 = 40; ss_done = 1;
    @(negedge clk);
    start_boost();
    run_ramp(60, tp, tn, t2, ts);
    chk(tp == 21, "R7 rail P at thr_p+1", tp, 21);
    chk(tn == 6, "R8 rail N at thr_n+1", tn, 6);
    chk(t2 == 41, "R9 rail 2 at thr_2+1", t2, 41);
    chk(ts == 41, "R9 switch drive with rail 2", ts, 41);
    conv_en = 0;
    @(negedge clk);
    chk(!boost_en && !rail_p_en && !rail_n_en && !rail_2_en,
        "R5 conv_en low turns boost and rails off", outs[4:0], 0);
  endtask

  task automatic t_order_b();
    int tp, tn, t2, ts;
    thr_p = 3; thr_n = 30; thr_2 = 12; ss_done = 0;
    @(negedge clk);
    start_boost();
    run_ramp(25, tp, tn, t2, ts);
    chk(tp == -1, "R7 rail P waits for ss_done", tp, -1);
    chk(t2 == 13, "R6 ramp restarted, rail 2 at 13", t2, 13);
    chk(tn == -1, "R8 rail N not yet", tn, -1);
    ss_done = 1;
    #1;
    chk(rail_p_en, "R7 rail P once ss_done rises", rail_p_en, 1);
    run_ramp(10, tp, tn, t2, ts);
    chk(tn == 6, "R8 rail N at ramp 31", tn, 6);
  endtask

  task automatic t_freeze_sat();
    int tp, tn, t2, ts;
    conv_en = 0;
    thr_n = 10; thr_p = 8'hFF; thr_2 = 8'hFF;
    @(negedge clk);
    @(negedge clk);
    start_boost();
    thr_n = 2;
    run_ramp(20, tp, tn, t2, ts);
    chk(tn == 11, "R13 threshold frozen during boost", tn, 11);
    run_ramp(300, tp, tn, t2, ts);
    chk(tp == -1 && t2 == -1, "R12 max threshold never enables", tp + t2, -2);
    chk(boost_en && rail_n_en, "R12 ramp saturates, rail N stays on",
        {boost_en, rail_n_en}, 3);
  endtask

  task automatic t_fault_uvlo();
    fault_in = 1;
    @(negedge clk);
    fault_in = 0;
    chk(!boost_en && !rail_n_en, "R10 fault stops boost and rails",
        {boost_en, rail_n_en}, 0);
    conv_en = 0;
    repeat (2) @(negedge clk);
    conv_en = 1;
    repeat (3) @(negedge clk);
    chk(!boost_en, "R11 conv_en toggle does not clear fault", boost_en, 1'b0);
    chk(aux1_en, "R10 earlier stages stay on under fault", aux1_en, 1);
    uvlo = 1;
    @(negedge clk);
    chk(!ref_en, "R2 uvlo returns to shutdown", ref_en, 0);
    fault_in = 1;  // counter is off: must be ignored
    @(negedge clk);
    fault_in = 0;
    bring_up();
    start_boost();
    chk(boost_en, "R11 uvlo cleared fault; R10 unarmed fault ignored", boost_en, 1);
  endtask

  task automatic t_fault_shdn();
    int tp, tn, t2, ts;
    run_ramp(5, tp, tn, t2, ts);
    chk(rail_n_en, "R8 rail N on before shutdown test", rail_n_en, 1);
    shdn_n = 0;
    #1;
    chk(outs == 0, "R1 shutdown clears outputs same cycle", outs, 0);
    bring_up();
    start_boost();
    fault_in = 1;
    @(negedge clk);
    fault_in = 0;
    chk(!boost_en, "R10 fault latched again", boost_en, 0);
    shdn_n = 0;
    @(negedge clk);
    bring_up();
    start_boost();
    chk(boost_en, "R11 shutdown toggle cleared fault", boost_en, 1);
  endtask

  initial begin
    t_reset();
    t_uvlo_hold();
    t_order_a();
    t_order_b();
    t_freeze_sat();
    t_fault_uvlo();
    t_fault_shdn();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule